// File: doc/BRIEF.md
# Pipelined Synchronous SRAM Access Controller

This block is the control path of a single-port synchronous SRAM whose inputs and outputs are both registered. At every rising clock edge it classifies the sampled control pins as one of five events: idle, deselect, read start, write start or burst continue. From that event it drives the array read and write strobes, a per-byte write mask and the enable of the tristate data driver. A small behavioural array is instantiated inside so the whole path can be exercised end to end.

Two address strobes can open an access. The processor strobe only counts while the first chip select is active. An access it opens always begins as a read, and any write is decided one edge later. The controller strobe decides read or write in the same edge from the write enables. Once an access is open, edges without a strobe continue it. The advance pin then either steps a two-bit wrapping burst counter or holds the current word. The counter runs in linear order or in interleaved (XOR) order, chosen by a static strap.

Top module: `pss_ctl`

## Requirements
- R1: A read starts at an edge where either strobe is accepted, all three selects are active (sel_a_n=0, sel_b=1, sel_c_n=0) and both wr_all_n and wr_byte_n are high. After the following edge, with oe_n low, drive_o is 1 and rdata_o holds the addressed word.
- R2: cpu_as_n low while sel_a_n is high is ignored. If the block is deselected it stays deselected, with no data driven two edges later. If a burst is open, the edge is a plain burst continue: it is neither a deselect nor a new access at the new address.
- R3: Read data is registered. It appears one edge after the address is captured, and drive_o follows oe_n combinationally (oe_n high gives drive_o=0 at once).
- R4: In the first cycle after an edge that opens an access out of the deselected state, drive_o is 0 whatever oe_n is.
- R5: An edge with an accepted strobe and any select inactive deselects the block, and drive_o is 0 right after that edge.
- R6: An access opened by the processor strobe takes two edges to write. At the opening edge the write enables, the write data and adv_n are ignored. The write enables at the next edge decide the write, which lands at the opening address when adv_n is high.
- R7: wr_all_n low writes all four byte lanes, whatever wr_byte_n and byte_sel_n hold.
- R8: With wr_all_n high and wr_byte_n low, byte lane i (bits 8i+7..8i) is written exactly when byte_sel_n[i] is low. All other lanes keep their contents, and this includes a write with no lane selected.
- R9: At any edge that performs a write (wr_all_n or wr_byte_n low in an open access, outside the opening edge of the processor strobe), drive_o is 0 right after that edge whatever oe_n is.
- R10: An edge with no accepted strobe while an access is open continues the burst. With adv_n low the counter n steps by one, modulo 4. The word offset is (start+n) mod 4 when linear_i=1 and start XOR n when linear_i=0, and the upper address bits stay fixed. With adv_n high the same word is accessed again.
- R11: A controller strobe accepted with wr_all_n or wr_byte_n low writes wdata_i at addr_i in that same edge.
- R12: During and right after reset drive_o is 0 and the block is deselected, so edges without a strobe perform no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | AW | Word address sampled with a strobe |
| cpu_as_n | input | 1 | Processor address strobe, active low, gated by sel_a_n |
| ctl_as_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel_a_n | input | 1 | First chip select, active low |
| sel_b | input | 1 | Second chip select, active high |
| sel_c_n | input | 1 | Third chip select, active low |
| wr_all_n | input | 1 | Global write enable, active low |
| wr_byte_n | input | 1 | Byte write enable, active low |
| byte_sel_n | input | NB | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| linear_i | input | 1 | Static burst order: 1 linear, 0 interleaved |
| wdata_i | input | NB*BW | Write data |
| rdata_o | output | NB*BW | Registered read data |
| drive_o | output | 1 | Enable of the external tristate data driver |

## Verification
The sharpest overlap is a write edge that lands while registered read data is about to be driven. The pipelined read from the previous edge is still loaded into the output register, and the write must suppress its drive in that same edge. The bench provokes this by opening a read, letting a burst continue drive data, and then asserting a write with an empty lane mask. It judges at the ports: drive_o must fall right after the write edge, and a later read must return the untouched word. A second overlap occurs when a gated processor strobe shares an edge with an open burst. The check there is that the burst word keeps coming out and the new address is never read.

// File: rtl/pss_pkg.sv
package pss_pkg;

  localparam int BURST_W = 2;

  typedef enum logic [2:0] {
    EV_IDLE,
    EV_DESEL,
    EV_START_RD,
    EV_START_WR,
    EV_CONT
  } ev_t;

  // word offset inside a burst: linear adds, interleaved XORs
  function automatic logic [BURST_W-1:0] burst_lo(
    input logic [BURST_W-1:0] start,
    input logic [BURST_W-1:0] step,
    input logic               lin
  );
    return lin ? (start + step) : (start ^ step);
  endfunction

  function automatic logic is_start(input ev_t ev);
    return (ev == EV_START_RD) || (ev == EV_START_WR);
  endfunction

endpackage

// File: rtl/pss_decode.sv
module pss_decode
  import pss_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic          cpu_as_n,
  input  logic          ctl_as_n,
  input  logic          sel_a_n,
  input  logic          sel_b,
  input  logic          sel_c_n,
  input  logic          wr_all_n,
  input  logic          wr_byte_n,
  input  logic [NB-1:0] byte_sel_n,
  input  logic          active_i,
  output ev_t           ev_o,
  output logic          wr_seen_o,
  output logic [NB-1:0] mask_o
);

  logic cpu_go;
  logic any_as;
  logic all_sel;

  assign cpu_go    = !cpu_as_n && !sel_a_n;
  assign any_as    = cpu_go || !ctl_as_n;
  assign all_sel   = !sel_a_n && sel_b && !sel_c_n;
  assign wr_seen_o = !wr_all_n || !wr_byte_n;

  always_comb begin
    if (any_as && !all_sel)
      ev_o = EV_DESEL;
    else if (any_as)
      ev_o = (cpu_go || !wr_seen_o) ? EV_START_RD : EV_START_WR;
    else if (active_i)
      ev_o = EV_CONT;
    else
      ev_o = EV_IDLE;
  end

  for (genvar g = 0; g < NB; g++) begin : g_lane_mask
    assign mask_o[g] = !wr_all_n || (!wr_byte_n && !byte_sel_n[g]);
  end

endmodule

// File: rtl/pss_burst.sv
module pss_burst
  import pss_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ev_t           ev_i,
  input  logic          adv_n,
  input  logic          linear_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] acc_addr_o,
  output logic          active_o
);

  localparam int CW = BURST_W;

  logic [AW-1:0] base_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] nxt_cnt;
  logic          active_q;

  assign nxt_cnt  = cnt_q + {{(CW-1){1'b0}}, ~adv_n};
  assign active_o = active_q;

  always_comb begin
    if (is_start(ev_i))
      acc_addr_o = addr_i;
    else
      acc_addr_o = {base_q[AW-1:CW], burst_lo(base_q[CW-1:0], nxt_cnt, linear_i)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
    end else begin
      case (ev_i)
        EV_DESEL: active_q <= 1'b0;
        EV_START_RD, EV_START_WR: begin
          active_q <= 1'b1;
          base_q   <= addr_i;
          cnt_q    <= '0;
        end
        EV_CONT:  cnt_q <= nxt_cnt;
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/pss_array.sv
module pss_array #(
  parameter int AW = 6,
  parameter int NB = 4,
  parameter int BW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [NB-1:0]    mask_i,
  input  logic             re_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [NB*BW-1:0] wdata_i,
  output logic             pend_o,
  output logic [NB*BW-1:0] dout_o
);

  localparam int DEPTH = 1 << AW;
  localparam int DW    = NB * BW;

  logic [AW-1:0] rd_addr_q;
  logic          pend_q;
  logic [DW-1:0] dout_q;
  logic [DW-1:0] lane_rd;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [BW-1:0] mem_l [DEPTH];
    always_ff @(posedge clk) begin
      if (we_i && mask_i[g])
        mem_l[addr_i] <= wdata_i[g*BW +: BW];
    end
    assign lane_rd[g*BW +: BW] = mem_l[rd_addr_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_addr_q <= '0;
      pend_q    <= 1'b0;
      dout_q    <= '0;
    end else begin
      pend_q <= re_i;
      if (re_i)
        rd_addr_q <= addr_i;
      if (pend_q)
        dout_q <= lane_rd;
    end
  end

  assign pend_o = pend_q;
  assign dout_o = dout_q;

endmodule

// File: rtl/pss_ctl.sv
module pss_ctl
  import pss_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 4,
  parameter int BW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr_i,
  input  logic             cpu_as_n,
  input  logic             ctl_as_n,
  input  logic             adv_n,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             wr_all_n,
  input  logic             wr_byte_n,
  input  logic [NB-1:0]    byte_sel_n,
  input  logic             oe_n,
  input  logic             linear_i,
  input  logic [NB*BW-1:0] wdata_i,
  output logic [NB*BW-1:0] rdata_o,
  output logic             drive_o
);

  localparam int DW = NB * BW;

  ev_t           ev;
  logic          wr_seen;
  logic [NB-1:0] arr_mask;
  logic          active_q;
  logic [AW-1:0] acc_addr;
  logic          rd_pend;
  logic [DW-1:0] dout;
  logic          drive_q;

  // named events, also watched by the checker
  logic start_evt;
  logic wake_evt;
  logic desel_evt;
  logic wr_evt;
  logic rd_evt;
  logic arr_we;

  pss_decode #(.NB(NB)) u_dec (
    .cpu_as_n   (cpu_as_n),
    .ctl_as_n   (ctl_as_n),
    .sel_a_n    (sel_a_n),
    .sel_b      (sel_b),
    .sel_c_n    (sel_c_n),
    .wr_all_n   (wr_all_n),
    .wr_byte_n  (wr_byte_n),
    .byte_sel_n (byte_sel_n),
    .active_i   (active_q),
    .ev_o       (ev),
    .wr_seen_o  (wr_seen),
    .mask_o     (arr_mask)
  );

  pss_burst #(.AW(AW)) u_burst (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_i       (ev),
    .adv_n      (adv_n),
    .linear_i   (linear_i),
    .addr_i     (addr_i),
    .acc_addr_o (acc_addr),
    .active_o   (active_q)
  );

  assign start_evt = is_start(ev);
  assign wake_evt  = start_evt && !active_q;
  assign desel_evt = (ev == EV_DESEL);
  assign wr_evt    = (ev == EV_START_WR) || ((ev == EV_CONT) && wr_seen);
  assign rd_evt    = (ev == EV_START_RD) || ((ev == EV_CONT) && !wr_seen);
  assign arr_we    = wr_evt;

  pss_array #(.AW(AW), .NB(NB), .BW(BW)) u_arr (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (arr_we),
    .mask_i  (arr_mask),
    .re_i    (rd_evt),
    .addr_i  (acc_addr),
    .wdata_i (wdata_i),
    .pend_o  (rd_pend),
    .dout_o  (dout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      drive_q <= 1'b0;
    else
      drive_q <= rd_pend && !wr_evt && !desel_evt && !wake_evt;
  end

  assign drive_o = drive_q && !oe_n;
  assign rdata_o = dout;

endmodule

// File: rtl/pss_ctl_chk.sv
module pss_ctl_chk #(
  parameter int NB = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_as_n,
  input logic          ctl_as_n,
  input logic          sel_a_n,
  input logic          wr_all_n,
  input logic          wr_byte_n,
  input logic [NB-1:0] byte_sel_n,
  input logic          drive_o,
  input logic          start_evt,
  input logic          wake_evt,
  input logic          desel_evt,
  input logic          rd_evt,
  input logic          arr_we,
  input logic [NB-1:0] arr_mask
);

  AST_GATED_PROC_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_as_n && sel_a_n && ctl_as_n) |-> !(start_evt || desel_evt)); // R2

  AST_PROC_FIRST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_as_n && !sel_a_n) |-> !arr_we); // R6

  AST_GLOBAL_FULL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && !wr_all_n) |-> (&arr_mask)); // R7

  AST_BYTE_MASK_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && wr_all_n && !wr_byte_n) |-> (arr_mask == ~byte_sel_n)); // R8

  AST_WRITE_TRISTATE: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |=> !drive_o); // R9

  AST_DESEL_TRISTATE: assert property (@(posedge clk) disable iff (!rst_n)
    desel_evt |=> !drive_o); // R5

  AST_WAKE_TRISTATE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> !drive_o); // R4

  AST_DRIVE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    drive_o |-> $past(rd_evt, 2)); // R3

endmodule

bind pss_ctl pss_ctl_chk #(.NB(NB)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_as_n   (cpu_as_n),
  .ctl_as_n   (ctl_as_n),
  .sel_a_n    (sel_a_n),
  .wr_all_n   (wr_all_n),
  .wr_byte_n  (wr_byte_n),
  .byte_sel_n (byte_sel_n),
  .drive_o    (drive_o),
  .start_evt  (start_evt),
  .wake_evt   (wake_evt),
  .desel_evt  (desel_evt),
  .rd_evt     (rd_evt),
  .arr_we     (arr_we),
  .arr_mask   (arr_mask)
);

// File: tb/pss_ctl_test.sv
module pss_ctl_test;

  localparam int AW = 6;
  localparam int NB = 4;
  localparam int BW = 8;
  localparam int DW = NB * BW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          cpu_as_n = 1'b1, ctl_as_n = 1'b1, adv_n = 1'b1;
  logic          sel_a_n = 1'b0, sel_b = 1'b1, sel_c_n = 1'b0;
  logic          wr_all_n = 1'b1, wr_byte_n = 1'b1;
  logic [NB-1:0] byte_sel_n = '1;
  logic          oe_n = 1'b0, linear_i = 1'b1;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          drive_o;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;
  logic [DW-1:0] model [DEPTH];

  always #4 clk = ~clk;

  pss_ctl #(.AW(AW), .NB(NB), .BW(BW)) uut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .cpu_as_n(cpu_as_n),
    .ctl_as_n(ctl_as_n), .adv_n(adv_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n),
    .byte_sel_n(byte_sel_n), .oe_n(oe_n), .linear_i(linear_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .drive_o(drive_o)
  );

  function automatic logic [DW-1:0] pat(input int k);
    return DW'(k + 1) * 32'h9E37_79B9;
  endfunction

  function automatic int seq_off(input int lo, input int n, input logic lin);
    return lin ? ((lo + n) % 4) : (lo ^ (n % 4));
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_write(input int a, input logic [DW-1:0] d, input logic all_n,
                             input logic byte_n, input logic [NB-1:0] sel_n);
    for (int i = 0; i < NB; i++)
      if (!all_n || (!byte_n && !sel_n[i]))
        model[a][i*BW +: BW] = d[i*BW +: BW];
  endtask

  task automatic desel();
    oe_n = 1'b0; ctl_as_n = 1'b0; sel_b = 1'b0;
    tick();
    check("R5", DW'(drive_o), '0);
    ctl_as_n = 1'b1; sel_b = 1'b1;
  endtask

  task automatic ctl_write(input int a, input logic [DW-1:0] d, input logic all_n,
                           input logic byte_n, input logic [NB-1:0] sel_n);
    desel();
    ctl_as_n = 1'b0; addr_i = AW'(a); wdata_i = d;
    wr_all_n = all_n; wr_byte_n = byte_n; byte_sel_n = sel_n;
    tick();
    check("R9", DW'(drive_o), '0);
    model_write(a, d, all_n, byte_n, sel_n);
    ctl_as_n = 1'b1; wr_all_n = 1'b1; wr_byte_n = 1'b1; byte_sel_n = '1;
    desel();
  endtask

  task automatic do_read(input int a, input logic use_cpu, input string req);
    desel();
    addr_i = AW'(a);
    if (use_cpu) cpu_as_n = 1'b0; else ctl_as_n = 1'b0;
    tick();
    check("R4", DW'(drive_o), '0);
    cpu_as_n = 1'b1; ctl_as_n = 1'b1;
    tick();
    check(req, DW'(drive_o), DW'(1));
    check(req, rdata_o, model[a]);
    oe_n = 1'b1;
    #1;
    check("R3", DW'(drive_o), '0);
    oe_n = 1'b0;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R12: reset state and idle after release
    repeat (3) tick();
    check("R12", DW'(drive_o), '0);
    rst_n = 1'b1;
    tick(); tick();
    check("R12", DW'(drive_o), '0);

    // fill through controller strobe global writes (R11)
    for (int a = 0; a < DEPTH; a++) ctl_write(a, pat(a), 1'b0, 1'b1, '1);

    // read sweep: even words via processor strobe, odd via controller strobe
    for (int a = 0; a < DEPTH; a++) begin
      if (a % 2 == 0) do_read(a, 1'b1, "R1");
      else            do_read(a, 1'b0, "R11");
    end

    // R8: every byte-select pattern on one word
    for (int m = 0; m < 16; m++) begin
      ctl_write(5, pat(100 + m), 1'b1, 1'b0, ~NB'(m));
      do_read(5, 1'b0, "R8");
    end

    // R7: global write overrides byte inputs
    ctl_write(9, pat(200), 1'b0, 1'b0, 4'b1010);
    do_read(9, 1'b0, "R7");
    ctl_write(10, pat(201), 1'b0, 1'b1, 4'b1111);
    do_read(10, 1'b1, "R7");

    // R9 + R8: empty-mask write lands while read data is being driven
    desel();
    ctl_as_n = 1'b0; addr_i = AW'(12);
    tick();
    ctl_as_n = 1'b1;
    tick();
    check("R1", DW'(drive_o), DW'(1));
    wr_byte_n = 1'b0; byte_sel_n = '1; wdata_i = 32'hFFFF_FFFF;
    tick();
    check("R9", DW'(drive_o), '0);
    wr_byte_n = 1'b1;
    do_read(12, 1'b0, "R8");

    // R6: processor-strobe write, first-edge write inputs ignored
    desel();
    cpu_as_n = 1'b0; addr_i = AW'(20); wr_all_n = 1'b0; adv_n = 1'b0;
    wdata_i = 32'hDEAD_BEEF;
    tick();
    check("R6", DW'(drive_o), '0);
    cpu_as_n = 1'b1; adv_n = 1'b1; wr_all_n = 1'b1;
    wr_byte_n = 1'b0; byte_sel_n = 4'b1100; wdata_i = pat(300);
    tick();
    check("R9", DW'(drive_o), '0);
    model_write(20, pat(300), 1'b1, 1'b0, 4'b1100);
    wr_byte_n = 1'b1; byte_sel_n = '1;
    do_read(20, 1'b1, "R6");

    // R2: gated processor strobe while deselected
    desel();
    cpu_as_n = 1'b0; sel_a_n = 1'b1; addr_i = AW'(7);
    tick();
    cpu_as_n = 1'b1; sel_a_n = 1'b0;
    tick();
    check("R2", DW'(drive_o), '0);

    // R2: gated processor strobe during an open burst is a continue
    desel();
    ctl_as_n = 1'b0; addr_i = AW'(30);
    tick();
    ctl_as_n = 1'b1; cpu_as_n = 1'b0; sel_a_n = 1'b1; addr_i = AW'(31);
    tick();
    check("R2", DW'(drive_o), DW'(1));
    check("R2", rdata_o, model[30]);
    cpu_as_n = 1'b1; sel_a_n = 1'b0;
    tick();
    check("R2", rdata_o, model[30]);

    // R10: burst read in both orders from every start offset
    for (int lin = 0; lin < 2; lin++) begin
      for (int lo = 0; lo < 4; lo++) begin
        linear_i = lin[0];
        desel();
        ctl_as_n = 1'b0; addr_i = AW'(40 + lo);
        tick();
        ctl_as_n = 1'b1; adv_n = 1'b0;
        for (int j = 1; j <= 5; j++) begin
          if (j == 5) adv_n = 1'b1;
          tick();
          check("R10", rdata_o, model[40 + seq_off(lo, j - 1, lin[0])]);
        end
        tick();
        check("R10", rdata_o, model[40 + seq_off(lo, 4, lin[0])]);
        check("R10", DW'(drive_o), DW'(1));
      end
    end

    // R10: interleaved burst write, second word goes to offset 1^1=0
    linear_i = 1'b0;
    desel();
    ctl_as_n = 1'b0; addr_i = AW'(45); wr_all_n = 1'b0; wdata_i = pat(400);
    tick();
    ctl_as_n = 1'b1; adv_n = 1'b0; wdata_i = pat(401);
    tick();
    adv_n = 1'b1; wr_all_n = 1'b1;
    model[45] = pat(400);
    model[44] = pat(401);
    do_read(45, 1'b0, "R10");
    do_read(44, 1'b0, "R10");
    do_read(46, 1'b0, "R10");
    linear_i = 1'b1;

    // R5: deselect while data is driven
    desel();
    ctl_as_n = 1'b0; addr_i = AW'(50);
    tick();
    ctl_as_n = 1'b1;
    tick();
    check("R1", DW'(drive_o), DW'(1));
    ctl_as_n = 1'b0; sel_c_n = 1'b1;
    tick();
    check("R5", DW'(drive_o), '0);
    ctl_as_n = 1'b1; sel_c_n = 1'b0;
    tick();
    check("R5", DW'(drive_o), '0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule